// File: doc/BRIEF.md
# Receive Clock Eye Centring Controller

This controller calibrates the receive-clock delay of a source-synchronous link. Once the delay line reports lock, it sends a start-init command to the far end. The far end then returns a known training pattern. The controller steps a tap index from zero, rewrites the delay control word at each step, and waits a programmable number of cycles before judging the pattern. From the sweeps it finds where the passing window starts and where it ends.

The window may straddle the wrap point of the delay period. When tap zero already passes, the controller first walks to the end of the window and then to its start. It counts the width across the wrap by adding one period, and reduces the centre modulo the period. The centre tap is programmed back. The controller then waits for the far end to return the cycle-index sync word, and finishes with a lock sequence of two argument writes and a command. Failures end in an error code whose low nibble names the failing phase.

Top module: `eye_trainer`

## Requirements
- R1: After `start`, no command, argument or delay write is issued until `dl_lock` is high.
- R2: The delay period is `dl_hold + 6` taps. No delay write ever carries a tap above the period, and every sweep stops once the tap index equals the period.
- R3: A tap passes only when `rise_lo == fall_lo` and `rise_hi == ~fall_hi`. If either comparison fails, the tap fails.
- R4: Each delay write pulses `dl_ctrl_wr` with `dl_ctrl` holding the tap in bits 23:16 and bit 0 set; all other bits are zero.
- R5: Training opens with an argument write of 0x5C00, then a command write of 0x01. The first delay write after that carries tap 0.
- R6: When tap 0 passes, the end tap E is the first failing tap counted up from 0 (or the period P if none fails). The start tap S is the first passing tap at or above E (or P). The width is E + P − S.
- R7: When tap 0 fails, S is the first passing tap counted up from 0. E is the first failing tap at or above S (or P). The width is E − S.
- R8: The programmed and reported final tap is (S + width/2) mod P, always below P.
- R9: After each delay write, the pattern is judged no earlier than `settle_cycles + 2` rising edges after the edge that performs the write.
- R10: After centring, the controller waits for `rise_lo == 0x0A7014E0`. If this does not arrive within `TIMEOUT_CYCLES` cycles, it stops with `err` and `err_code` 0xCACAB0F3.
- R11: If no tap below P passes, the controller stops with `err` and `err_code` 0xCACAB0F1, with no lock sequence.
- R12: On success, the controller writes argument 0x4C727354, then argument 0x4C6F634B, then command 0x03, and only then raises `done`.
- R13: `done` and `err` are never high together. Each stays high until the next `start`, and `start` has no effect while training is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a training run |
| dl_lock | input | 1 | Delay line master lock flag |
| dl_hold | input | 8 | Master hold count; period = value + 6 |
| settle_cycles | input | CNT_W | Extra wait after each delay write |
| rise_lo | input | 32 | Rising-edge response, low word |
| rise_hi | input | 32 | Rising-edge response, high word |
| fall_lo | input | 32 | Falling-edge response, low word |
| fall_hi | input | 32 | Falling-edge response, high word |
| dl_ctrl | output | 32 | Delay control word |
| dl_ctrl_wr | output | 1 | Delay control write strobe |
| link_arg | output | 32 | Link init argument |
| link_arg_wr | output | 1 | Argument write strobe |
| link_cmd | output | 8 | Link init command |
| link_cmd_wr | output | 1 | Command write strobe |
| done | output | 1 | Training succeeded (held) |
| err | output | 1 | Training failed (held) |
| err_code | output | 32 | Failure code, zero unless `err` |
| final_tap | output | TAP_W | Centred tap of the last success |

## Verification
Two decisions can fall on the same sample: the pattern verdict, which asks for another step, and the period limit, which forbids one. The bench provokes this with windows that end exactly at tap P−1 and with windows that cover every tap. It also sweeps every start position and every length for a small period, and for a second period. Each run is judged by comparing the reported centre against an arithmetic model and by checking that no delay write ever went past the period. The bench's response model lags each delay write by the settle time, so a controller that judges the pattern too early reads a stale tap and misplaces the window.

// File: rtl/eye_pkg.sv
package eye_pkg;

    typedef enum logic [3:0] {
        ST_IDLE, ST_LOCK, ST_ARG, ST_CMD, ST_SET, ST_SETTLE, ST_SAMPLE,
        ST_CENTRE, ST_APPLY, ST_SYNC, ST_LK1, ST_LK2, ST_LK3, ST_DONE, ST_FAIL
    } state_e;

    // Which edge of the window the current sweep is hunting for.
    typedef enum logic [2:0] {
        PH_PROBE, PH_END_WRAP, PH_START_WRAP, PH_START, PH_END
    } phase_e;

    localparam logic [31:0] ARG_OPEN   = 32'h0000_5C00;
    localparam logic [7:0]  CMD_OPEN   = 8'h01;
    localparam logic [31:0] ARG_SEAL_A = 32'h4C72_7354;
    localparam logic [31:0] ARG_SEAL_B = 32'h4C6F_634B;
    localparam logic [7:0]  CMD_SEAL   = 8'h03;
    localparam logic [31:0] ERR_BASE   = 32'hCACA_B0F0;
    localparam logic [3:0]  ERR_NO_EYE = 4'h1;
    localparam logic [3:0]  ERR_SYNC   = 4'h3;

endpackage

// File: rtl/eye_pattern_cmp.sv
module eye_pattern_cmp #(
    parameter int W = 32
) (
    input  logic [W-1:0] rise_lo,
    input  logic [W-1:0] rise_hi,
    input  logic [W-1:0] fall_lo,
    input  logic [W-1:0] fall_hi,
    output logic         pass
);
    logic lo_same;
    logic hi_inv;

    always_comb begin
        lo_same = (rise_lo == fall_lo);
        hi_inv  = (rise_hi == ~fall_hi);
        pass    = lo_same && hi_inv;
    end
endmodule

// File: rtl/eye_centre.sv
module eye_centre #(
    parameter int PW = 9
) (
    input  logic [PW-1:0] first,
    input  logic [PW-1:0] last,
    input  logic [PW-1:0] period,
    input  logic          wrap,
    output logic [PW-1:0] centre
);
    localparam int XW = PW + 1;

    logic [XW-1:0] width;
    logic [XW-1:0] sum;
    logic [XW-1:0] folded;

    always_comb begin
        if (wrap)
            width = {1'b0, last} + {1'b0, period} - {1'b0, first};
        else
            width = {1'b0, last} - {1'b0, first};
        sum = {1'b0, first} + (width >> 1);
        if (sum >= {1'b0, period})
            folded = sum - {1'b0, period};
        else
            folded = sum;
        centre = folded[PW-1:0];
    end
endmodule

// File: rtl/eye_trainer.sv
module eye_trainer
    import eye_pkg::*;
#(
    parameter int          TAP_W          = 8,
    parameter int          CNT_W          = 8,
    parameter int          TIMEOUT_CYCLES = 1000,
    parameter logic [31:0] SYNC_WORD      = 32'h0A70_14E0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             dl_lock,
    input  logic [7:0]       dl_hold,
    input  logic [CNT_W-1:0] settle_cycles,
    input  logic [31:0]      rise_lo,
    input  logic [31:0]      rise_hi,
    input  logic [31:0]      fall_lo,
    input  logic [31:0]      fall_hi,
    output logic [31:0]      dl_ctrl,
    output logic             dl_ctrl_wr,
    output logic [31:0]      link_arg,
    output logic             link_arg_wr,
    output logic [7:0]       link_cmd,
    output logic             link_cmd_wr,
    output logic             done,
    output logic             err,
    output logic [31:0]      err_code,
    output logic [TAP_W-1:0] final_tap
);
    localparam int PW    = TAP_W + 1;
    localparam int TMR_W = $clog2(TIMEOUT_CYCLES + 1);

    typedef struct packed {
        state_e           state;
        phase_e           phase;
        logic [PW-1:0]    tap;
        logic [PW-1:0]    first;
        logic [PW-1:0]    last;
        logic             wrap;
        logic [CNT_W-1:0] cnt;
        logic [TMR_W-1:0] timer;
        logic [TAP_W-1:0] fin;
        logic             done;
        logic             err;
        logic [3:0]       ecode;
    } regs_t;

    regs_t q, d;

    logic [PW-1:0] period;
    logic          pass;
    logic          want_step;
    logic [PW-1:0] centre;

    assign period = PW'(dl_hold) + PW'(6);

    eye_pattern_cmp #(.W(32)) u_cmp (
        .rise_lo(rise_lo), .rise_hi(rise_hi),
        .fall_lo(fall_lo), .fall_hi(fall_hi),
        .pass(pass)
    );

    eye_centre #(.PW(PW)) u_ctr (
        .first(q.first), .last(q.last), .period(period),
        .wrap(q.wrap), .centre(centre)
    );

    always_comb begin
        d = q;
        want_step = (q.phase == PH_END_WRAP || q.phase == PH_END) ? pass : !pass;
        case (q.state)
            ST_IDLE, ST_DONE, ST_FAIL: begin
                if (start) begin
                    d.state = ST_LOCK;
                    d.done  = 1'b0;
                    d.err   = 1'b0;
                    d.ecode = '0;
                end
            end
            ST_LOCK:  if (dl_lock) d.state = ST_ARG;
            ST_ARG:   d.state = ST_CMD;
            ST_CMD: begin
                d.tap   = '0;
                d.phase = PH_PROBE;
                d.state = ST_SET;
            end
            ST_SET: begin
                d.cnt   = '0;
                d.state = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (q.cnt >= settle_cycles) d.state = ST_SAMPLE;
                else                        d.cnt   = q.cnt + 1'b1;
            end
            ST_SAMPLE: begin
                if (q.phase == PH_PROBE) begin
                    d.wrap  = pass;
                    d.phase = pass ? PH_END_WRAP : PH_START;
                end else if (want_step && q.tap < period) begin
                    d.tap   = q.tap + 1'b1;
                    d.state = ST_SET;
                end else begin
                    case (q.phase)
                        PH_END_WRAP: begin
                            d.last  = q.tap;
                            d.phase = PH_START_WRAP;
                        end
                        PH_START_WRAP: begin
                            d.first = q.tap;
                            d.state = ST_CENTRE;
                        end
                        PH_START: begin
                            if (q.tap == period) begin
                                d.state = ST_FAIL;
                                d.err   = 1'b1;
                                d.ecode = ERR_NO_EYE;
                            end else begin
                                d.first = q.tap;
                                d.phase = PH_END;
                            end
                        end
                        default: begin
                            d.last  = q.tap;
                            d.state = ST_CENTRE;
                        end
                    endcase
                end
            end
            ST_CENTRE: begin
                d.tap   = centre;
                d.fin   = centre[TAP_W-1:0];
                d.timer = '0;
                d.state = ST_APPLY;
            end
            ST_APPLY: d.state = ST_SYNC;
            ST_SYNC: begin
                if (rise_lo == SYNC_WORD) begin
                    d.state = ST_LK1;
                end else if (q.timer == TMR_W'(TIMEOUT_CYCLES)) begin
                    d.state = ST_FAIL;
                    d.err   = 1'b1;
                    d.ecode = ERR_SYNC;
                end else begin
                    d.timer = q.timer + 1'b1;
                end
            end
            ST_LK1: d.state = ST_LK2;
            ST_LK2: d.state = ST_LK3;
            ST_LK3: begin
                d.state = ST_DONE;
                d.done  = 1'b1;
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, phase: PH_PROBE, default: '0};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        dl_ctrl_wr  = (q.state == ST_SET) || (q.state == ST_APPLY);
        dl_ctrl     = ({{(32-TAP_W){1'b0}}, q.tap[TAP_W-1:0]} << 16) | 32'd1;
        link_arg_wr = (q.state == ST_ARG) || (q.state == ST_LK1) || (q.state == ST_LK2);
        link_arg    = (q.state == ST_LK1) ? ARG_SEAL_A :
                      (q.state == ST_LK2) ? ARG_SEAL_B : ARG_OPEN;
        link_cmd_wr = (q.state == ST_CMD) || (q.state == ST_LK3);
        link_cmd    = (q.state == ST_LK3) ? CMD_SEAL : CMD_OPEN;
        done        = q.done;
        err         = q.err;
        err_code    = q.err ? (ERR_BASE | {28'd0, q.ecode}) : 32'd0;
        final_tap   = q.fin;
    end

    // Cycles since the last delay write, saturating; used only by a check.
    logic [CNT_W:0] since_wr_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    since_wr_q <= '0;
        else if (dl_ctrl_wr)           since_wr_q <= '0;
        else if (since_wr_q != '1)     since_wr_q <= since_wr_q + 1'b1;
    end

    assert_open_after_lock_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (link_arg_wr && link_arg == ARG_OPEN) |-> $past(dl_lock));

    assert_tap_in_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dl_ctrl_wr |-> (q.tap <= period));

    assert_final_below_period_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (PW'(final_tap) < period));

    assert_settle_respected_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_SAMPLE && $past(q.state) == ST_SETTLE)
            |-> (since_wr_q > {1'b0, settle_cycles}));

    assert_err_prefix_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (err_code[31:16] == 16'hCACA));

    assert_seal_before_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(link_cmd_wr) && $past(link_cmd) == CMD_SEAL));

    assert_done_err_exclusive_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));
endmodule

// File: tb/sim_eye_trainer.sv
module sim_eye_trainer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        dl_lock = 1'b1;
    logic [7:0]  dl_hold = 8'd2;
    logic [7:0]  settle_cycles = 8'd2;
    logic [31:0] rise_lo, rise_hi, fall_lo, fall_hi;
    logic [31:0] dl_ctrl, link_arg, err_code;
    logic        dl_ctrl_wr, link_arg_wr, link_cmd_wr, done, err;
    logic [7:0]  link_cmd, final_tap;

    always #10 clk = ~clk;

    eye_trainer u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .dl_lock(dl_lock),
        .dl_hold(dl_hold), .settle_cycles(settle_cycles),
        .rise_lo(rise_lo), .rise_hi(rise_hi), .fall_lo(fall_lo), .fall_hi(fall_hi),
        .dl_ctrl(dl_ctrl), .dl_ctrl_wr(dl_ctrl_wr),
        .link_arg(link_arg), .link_arg_wr(link_arg_wr),
        .link_cmd(link_cmd), .link_cmd_wr(link_cmd_wr),
        .done(done), .err(err), .err_code(err_code), .final_tap(final_tap)
    );

    int n_checks = 0;
    int n_fails  = 0;
    int cyc = 0;
    bit wd_fired = 0;

    int win_a = 0, win_len = 0, p_cur = 8;
    logic [31:0] word = 32'h0A70_14E0;
    int cur_tap = 0, seen_tap = 0, age = 0;
    int tap_viol = 0, fmt_viol = 0;
    bit want_first = 0;
    int first_tap_seen = -1;
    logic [31:0] arg_log [0:1023];
    logic [7:0]  cmd_log [0:1023];
    int n_arg = 0, n_cmd = 0;

    function automatic bit in_win(int t, int a, int len, int p);
        int tt = t % p;
        int off = (tt - a + p) % p;
        return (len > 0) && (off < len);
    endfunction

    // Response model: follows the applied tap only once the settle time has elapsed.
    logic pass_m;
    always_comb begin
        pass_m  = in_win(seen_tap, win_a, win_len, p_cur);
        rise_lo = word;
        rise_hi = 32'h5A5A_0F0F;
        if (pass_m) begin
            fall_lo = word;
            fall_hi = ~32'h5A5A_0F0F;
        end else if (seen_tap[0]) begin
            fall_lo = word ^ 32'h0001_0000;   // R3: low words differ
            fall_hi = ~32'h5A5A_0F0F;
        end else begin
            fall_lo = word;                   // R3: high word equal, not inverted
            fall_hi = 32'h5A5A_0F0F;
        end
    end

    always @(negedge clk) begin
        cyc++;
        if (dl_ctrl_wr) begin
            cur_tap = int'(dl_ctrl[23:16]);
            age = 0;
            if (cur_tap > p_cur) tap_viol++;
            if ((dl_ctrl & ~32'h00FF_0000) != 32'd1) fmt_viol++;
            if (want_first) begin
                first_tap_seen = cur_tap;
                want_first = 0;
            end
        end else if (age <= int'(settle_cycles) + 2) begin
            age++;
        end
        if (age == int'(settle_cycles) + 2) seen_tap = cur_tap;
        if (link_arg_wr) begin arg_log[n_arg % 1024] = link_arg; n_arg++; end
        if (link_cmd_wr) begin
            cmd_log[n_cmd % 1024] = link_cmd;
            n_cmd++;
            if (link_cmd == 8'h01) want_first = 1;
        end
        if (cyc >= 150000 && !wd_fired) begin
            wd_fired = 1;
            n_fails++;
            $display("FAIL watchdog: actual cycles %0d expected < 150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic void model(input int p, input int a, input int len,
                                  output bit ok, output int tap);
        int s, e, w;
        if (in_win(0, a, len, p)) begin
            e = 0;
            while (e < p && in_win(e, a, len, p)) e++;
            s = e;
            while (s < p && !in_win(s, a, len, p)) s++;
            w = e + p - s;
        end else begin
            s = 0;
            while (s < p && !in_win(s, a, len, p)) s++;
            if (s == p) begin ok = 0; tap = 0; return; end
            e = s;
            while (e < p && in_win(e, a, len, p)) e++;
            w = e - s;
        end
        ok = 1;
        tap = (s + w / 2) % p;
    endfunction

    task automatic run(input int hold, input int a, input int len, input int s,
                       input bit bad_sync, input bit late_lock, input bit poke);
        bit exp_ok;
        int exp_tap, base_arg, base_cmd, tv0, fv0, lim;
        dl_hold = 8'(hold);
        p_cur = hold + 6;
        win_a = a;
        win_len = len;
        settle_cycles = 8'(s);
        word = bad_sync ? 32'h1111_1111 : 32'h0A70_14E0;
        dl_lock = !late_lock;
        model(p_cur, a, len, exp_ok, exp_tap);
        if (bad_sync) exp_ok = 0;
        base_arg = n_arg; base_cmd = n_cmd; tv0 = tap_viol; fv0 = fmt_viol;
        first_tap_seen = -1;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(!done && !err, "R13 start clears status", {done, err}, 0);
        if (late_lock) begin
            repeat (15) @(negedge clk);
            chk(n_arg == base_arg && n_cmd == base_cmd, "R1 no writes before lock",
                n_arg - base_arg, 0);
            dl_lock = 1'b1;
        end
        if (poke) begin
            repeat (12) @(negedge clk);
            start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        lim = 0;
        while (!done && !err && lim < 5000) begin
            @(negedge clk);
            lim++;
        end
        chk(tap_viol == tv0, "R2 tap never above period", tap_viol - tv0, 0);
        chk(fmt_viol == fv0, "R4 control word format", fmt_viol - fv0, 0);
        chk(n_arg > base_arg && arg_log[base_arg % 1024] == 32'h5C00 &&
            cmd_log[base_cmd % 1024] == 8'h01, "R5 opening writes",
            arg_log[base_arg % 1024], 32'h5C00);
        chk(first_tap_seen == 0, "R5 first tap zero", first_tap_seen, 0);
        if (exp_ok) begin
            chk(done && !err, "R6 R7 training succeeds", {done, err}, 2'b10);
            chk(int'(final_tap) == exp_tap, "R8 centred tap", final_tap, exp_tap);
            chk(n_arg - base_arg == 3 && arg_log[(base_arg + 1) % 1024] == 32'h4C72_7354 &&
                arg_log[(base_arg + 2) % 1024] == 32'h4C6F_634B, "R12 seal arguments",
                arg_log[(base_arg + 1) % 1024], 32'h4C72_7354);
            chk(n_cmd - base_cmd == 2 && cmd_log[(base_cmd + 1) % 1024] == 8'h03,
                "R12 seal command", n_cmd - base_cmd, 2);
        end else begin
            chk(err && !done, "R11 R10 training fails", {done, err}, 2'b01);
            chk(err_code == (bad_sync ? 32'hCACA_B0F3 : 32'hCACA_B0F1), "R10 R11 error code",
                err_code, bad_sync ? 32'hCACA_B0F3 : 32'hCACA_B0F1);
            chk(n_arg - base_arg == 1 && n_cmd - base_cmd == 1, "R11 no seal on failure",
                n_cmd - base_cmd, 1);
        end
        repeat (5) @(negedge clk);
        chk(done == exp_ok && err == !exp_ok, "R13 status held", {done, err}, {exp_ok, !exp_ok});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!done && !err && !dl_ctrl_wr && !link_arg_wr && !link_cmd_wr && err_code == 0,
            "R13 reset state", {done, err, dl_ctrl_wr}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R6 R7 R8 R11: every window start and length for period 8
        for (int a = 0; a < 8; a++)
            for (int len = 0; len <= 8; len++)
                run(2, a, len, 2, 0, 0, 0);
        // second period, wrap-heavy windows, longer settle (R9)
        for (int a = 0; a < 10; a += 3)
            for (int len = 1; len <= 10; len += 2)
                run(4, a, len, 5, 0, 0, 0);
        run(2, 6, 3, 0, 0, 0, 0);       // R9 zero settle, window across wrap
        run(2, 3, 4, 2, 0, 1, 0);       // R1 late lock
        run(2, 5, 2, 2, 0, 0, 1);       // R13 start while busy ignored
        run(2, 2, 3, 2, 1, 0, 0);       // R10 sync timeout
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule